// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external asynchronous byte-wide static RAM of 2M locations, assembled from four banks of 512K. The host hands over one read or one write at a time on a valid/ready handshake, with a 21-bit location and a byte of write data. The controller then drives the active-low strobes, the row address and the data-bus drive enable through a fixed sequence. For a read, it returns the byte with a single-cycle valid pulse.

Every timing figure of the memory is a parameter in nanoseconds. Each one is turned into a whole number of clock cycles by rounding up, so one netlist serves any speed grade and clock period. The two upper address bits pick one of four active-low bank selects. The lower nineteen bits fan out to all banks. The address only changes while every strobe is high, and the controller drives the data bus only inside a write pulse.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, all four bank selects and both `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: `req_ready` is 1 only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, using the fields present at that edge. Fields shown while busy have no effect until that edge.
- R3: Bank select `mem_cs_n[k]` goes low only for a request whose `req_addr[20:19]` equals k, so at most one bit is low. `mem_addr` carries `req_addr[18:0]`.
- R4: The cycle after acceptance is a setup cycle: `mem_addr` already shows the new row while every bank select and both enables are high.
- R5: A write holds its bank select and `mem_we_n` low for exactly WP_CYC = ceil(T_WP_NS / CLK_NS) cycles, with `mem_oe_n` high. During those cycles, and only then, `mem_dq_oe` is 1 and `mem_dq_out` shows the accepted byte.
- R6: A read holds its bank select and `mem_oe_n` low for exactly RD_CYC = ceil(T_AA_NS / CLK_NS) cycles, with `mem_we_n` high and `mem_dq_oe` 0.
- R7: Read data is sampled from `mem_dq_in` on the edge that ends the last read-strobe cycle. It appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the first cycle after the strobes rise.
- R8: `mem_addr` does not change from the setup cycle until the controller returns to idle, so it never moves while a bank select and a strobe are low.
- R9: After each access every strobe stays high and `mem_dq_oe` stays 0 for REC_CYC cycles. REC_CYC is the largest of ceil(T_OHZ_NS / CLK_NS), WC_CYC - WP_CYC and RC_CYC - RD_CYC, and at least 1. After that `req_ready` returns to 1.
- R10: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0, and `mem_we_n` and `mem_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte location; bits 20:19 select the bank |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_cs_n | output | 4 | Active-low bank selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 19 | Row address shared by all banks |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 8 | Byte returned from the memory |

## Verification
The bench targets a request whose fields change while the controller is busy. A design that latched too early would write or read the stale location. It runs a write followed at once by a read of the same byte, and the boundary locations 0 and 2M-1. A wrong bank decode or a truncated row would then return a byte from another bank. The bench's memory model flags any address move while a bank select and write enable are both low, and any write pulse shorter than WP_CYC. It also flags any cycle where both sides drive the data bus. An off-by-one counter or an early data-bus enable would trip those checks. A read capture one edge early would return stale data, and a stretched valid would produce a duplicate response.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous SRAM controller.
// Assumes all timing inputs are positive integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_WPULSE  = 3'd2,
        ST_RWAIT   = 3'd3,
        ST_RECOVER = 3'd4
    } ctrl_state_e;

    // Ceiling division of a delay by the clock period, never below one cycle.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
        int unsigned r;
        r = (ns + clk_ns - 1) / clk_ns;
        if (r < 1) r = 1;
        return r;
    endfunction

    // Largest of three values.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    // Positive difference, zero when b exceeds a.
    function automatic int unsigned sub_floor0(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/sram_bank_decode.sv
// Turns the bank field into one-hot active-low bank selects.
// Assumes BANKS == 2**BANK_BITS; all selects stay high when en is low.
module sram_bank_decode #(
    parameter int BANK_BITS = 2,
    localparam int BANKS    = 1 << BANK_BITS
) (
    input  logic                 en,
    input  logic [BANK_BITS-1:0] bank,
    output logic [BANKS-1:0]     cs_n
);

    // One comparator per bank, selected by the bank field.
    for (genvar i = 0; i < BANKS; i++) begin : g_bank
        assign cs_n[i] = !(en && (bank == BANK_BITS'(i)));
    end

endmodule

// File: rtl/sram_req_latch.sv
// Captures the request fields on acceptance and holds them for the whole
// access, so the memory-side address and data never move mid-cycle.
// Assumes load is asserted only while the controller is idle.
module sram_req_latch #(
    parameter int ADDR_W    = 21,
    parameter int BANK_BITS = 2,
    parameter int DATA_W    = 8,
    localparam int ROW_W    = ADDR_W - BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 wr_q,
    output logic [BANK_BITS-1:0] bank_q,
    output logic [ROW_W-1:0]     row_q,
    output logic [DATA_W-1:0]    wdata_q
);

    // Hold the accepted request; clear to zero under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            bank_q  <= '0;
            row_q   <= '0;
            wdata_q <= '0;
        end else if (load) begin
            wr_q    <= req_write;
            bank_q  <= req_addr[ADDR_W-1:ROW_W];
            row_q   <= req_addr[ROW_W-1:0];
            wdata_q <= req_wdata;
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: idle, one setup cycle, a timed write pulse or read wait,
// then a timed recovery with all strobes high before the next request.
// Assumes every cycle count is at least one and fits in CNT_W bits.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned WP_CYC  = 2,
    parameter int unsigned RD_CYC  = 2,
    parameter int unsigned REC_CYC = 1,
    parameter int          CNT_W   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        wr_q,
    output ctrl_state_e state_o,
    output logic        accept_o,
    output logic        capture_o
);

    localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

    ctrl_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_done;

    assign cnt_done  = (cnt_q == '0);
    assign accept_o  = (state_q == ST_IDLE) && req_valid;
    assign capture_o = (state_q == ST_RWAIT) && cnt_done;
    assign state_o   = state_q;

    // Next-state and down-counter reload selection.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                state_d = wr_q ? ST_WPULSE : ST_RWAIT;
                cnt_d   = wr_q ? WP_LAST : RD_LAST;
            end
            ST_WPULSE, ST_RWAIT: begin
                if (cnt_done) begin
                    state_d = ST_RECOVER;
                    cnt_d   = REC_LAST;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt_done) state_d = ST_IDLE;
                else          cnt_d   = cnt_q - 1'b1;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State and counter registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
// Registers the returned byte on the capture edge and raises a one-cycle
// valid. Assumes capture is a single-cycle pulse from the sequencer.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Sample the bus and pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= dq_in;
        end
    end

endmodule

// File: rtl/sram_bus_ctrl.sv
// Synchronous front end for a banked asynchronous byte-wide SRAM. It takes one
// request at a time, drives row address and bank select, times the write or
// read strobe, and returns read data with a valid pulse. All memory timing is
// given in ns and rounded up to clock cycles. Assumes the host holds
// req_valid and its fields until accepted.
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int          ADDR_W    = 21,
    parameter int          BANK_BITS = 2,
    parameter int          DATA_W    = 8,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned T_WP_NS   = 15,
    parameter int unsigned T_WC_NS   = 20,
    parameter int unsigned T_AA_NS   = 20,
    parameter int unsigned T_RC_NS   = 20,
    parameter int unsigned T_OHZ_NS  = 9,
    localparam int BANKS = 1 << BANK_BITS,
    localparam int ROW_W = ADDR_W - BANK_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [BANKS-1:0]  mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ROW_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned WP_CYC  = ns_to_cycles(T_WP_NS, CLK_NS);
    localparam int unsigned WC_CYC  = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int unsigned RD_CYC  = ns_to_cycles(T_AA_NS, CLK_NS);
    localparam int unsigned RC_CYC  = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int unsigned TA_CYC  = ns_to_cycles(T_OHZ_NS, CLK_NS);
    localparam int unsigned REC_CYC = max3(TA_CYC, sub_floor0(WC_CYC, WP_CYC),
                                           sub_floor0(RC_CYC, RD_CYC));
    localparam int unsigned MAX_CYC = max3(WP_CYC, RD_CYC, REC_CYC);
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);

    ctrl_state_e          state;
    logic                 accept;
    logic                 capture;
    logic                 wr_q;
    logic [BANK_BITS-1:0] bank_q;
    logic [ROW_W-1:0]     row_q;
    logic [DATA_W-1:0]    wdata_q;
    logic                 strobe_en;

    sram_req_latch #(
        .ADDR_W    (ADDR_W),
        .BANK_BITS (BANK_BITS),
        .DATA_W    (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .wr_q      (wr_q),
        .bank_q    (bank_q),
        .row_q     (row_q),
        .wdata_q   (wdata_q)
    );

    sram_seq_fsm #(
        .WP_CYC  (WP_CYC),
        .RD_CYC  (RD_CYC),
        .REC_CYC (REC_CYC),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .wr_q      (wr_q),
        .state_o   (state),
        .accept_o  (accept),
        .capture_o (capture)
    );

    sram_bank_decode #(
        .BANK_BITS (BANK_BITS)
    ) u_decode (
        .en   (strobe_en),
        .bank (bank_q),
        .cs_n (mem_cs_n)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Strobe and bus-drive decode from the registered state.
    always_comb begin
        strobe_en = (state == ST_WPULSE) || (state == ST_RWAIT);
        mem_we_n  = (state != ST_WPULSE);
        mem_oe_n  = (state != ST_RWAIT);
        mem_dq_oe = (state == ST_WPULSE);
        req_ready = (state == ST_IDLE);
    end

    assign mem_addr   = row_q;
    assign mem_dq_out = wdata_q;

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
// Protocol checker for the SRAM controller, bound to the top module.
// Assumes WP_CYC and RD_CYC match the top module's derived cycle counts.
module sram_bus_ctrl_chk #(
    parameter int          BANKS  = 4,
    parameter int          ROW_W  = 19,
    parameter int unsigned WP_CYC = 2,
    parameter int unsigned RD_CYC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [BANKS-1:0] mem_cs_n,
    input logic             mem_we_n,
    input logic             mem_oe_n,
    input logic [ROW_W-1:0] mem_addr,
    input logic             mem_dq_oe
);

    logic        wr_active;
    int unsigned we_run;
    int unsigned oe_run;

    assign wr_active = !mem_we_n && !(&mem_cs_n);

    // Length of the current low run of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run <= 0;
            oe_run <= 0;
        end else begin
            we_run <= mem_we_n ? 0 : we_run + 1;
            oe_run <= mem_oe_n ? 0 : oe_run + 1;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (req_ready && (&mem_cs_n) && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid));

    a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((&mem_cs_n) && !mem_dq_oe));

    a_r3_onehot_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mem_we_n) && mem_we_n) |-> (we_run == WP_CYC));

    a_r6_read_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mem_oe_n) && mem_oe_n) |-> (oe_run == RD_CYC));

    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active && $past(wr_active)) |-> $stable(mem_addr));

    a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n) && !(!mem_we_n && !mem_oe_n));

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
    .BANKS  (BANKS),
    .ROW_W  (ROW_W),
    .WP_CYC (WP_CYC),
    .RD_CYC (RD_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_bus_ctrl_bench.sv
// Bench: behavioural reference of the access sequence plus a behavioural
// SRAM that flags protocol violations; all outputs compared every cycle.
module sram_bus_ctrl_bench;

    localparam int CLK_NS = 20;
    localparam int T_WP   = 35;
    localparam int T_WC   = 35;
    localparam int T_AA   = 35;
    localparam int T_RC   = 35;
    localparam int T_OHZ  = 30;
    localparam int WP  = (T_WP + CLK_NS - 1) / CLK_NS;
    localparam int RD  = (T_AA + CLK_NS - 1) / CLK_NS;
    localparam int WC  = (T_WC + CLK_NS - 1) / CLK_NS;
    localparam int RC  = (T_RC + CLK_NS - 1) / CLK_NS;
    localparam int TA  = (T_OHZ + CLK_NS - 1) / CLK_NS;
    localparam int REC_A = (WC > WP) ? WC - WP : 0;
    localparam int REC_B = (RC > RD) ? RC - RD : 0;
    localparam int REC = (TA >= REC_A && TA >= REC_B) ? TA : ((REC_A >= REC_B) ? REC_A : REC_B);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [3:0]  mem_cs_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in = '0;

    always #10 clk = ~clk;

    sram_bus_ctrl #(
        .CLK_NS (CLK_NS), .T_WP_NS (T_WP), .T_WC_NS (T_WC),
        .T_AA_NS (T_AA), .T_RC_NS (T_RC), .T_OHZ_NS (T_OHZ)
    ) u_sram_bus_ctrl (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
        .mem_addr (mem_addr), .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe),
        .mem_dq_in (mem_dq_in)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Initial content of a location nobody has written.
    function automatic logic [7:0] seed_byte(input int unsigned a);
        return a[7:0] ^ a[15:8] ^ {3'b0, a[20:16]} ^ 8'h5A;
    endfunction

    logic [7:0] ref_mem  [int unsigned];
    logic [7:0] sram_mem [int unsigned];

    // ---------------- reference model of the sequence ----------------
    int          ph = 0;     // 0 idle, 1 setup, 2 strobe, 3 recover
    int          cnt = 0;
    bit          m_wr = 1'b0;
    logic [20:0] m_addr = '0;
    logic [7:0]  m_wd = '0;
    bit          e_valid = 1'b0;
    logic [7:0]  e_data = '0;
    bit          last_accept = 1'b0;

    always @(posedge clk) begin
        started = 1'b1;
        last_accept = 1'b0;
        e_valid = 1'b0;
        if (!rst_n) begin
            ph = 0;
            cnt = 0;
        end else begin
            case (ph)
                0: if (req_valid) begin
                    ph = 1; m_wr = req_write; m_addr = req_addr; m_wd = req_wdata;
                    last_accept = 1'b1;
                    if (m_wr) ref_mem[int'(m_addr)] = m_wd;
                end
                1: begin ph = 2; cnt = m_wr ? WP : RD; end
                2: begin
                    cnt--;
                    if (cnt == 0) begin
                        if (!m_wr) begin
                            e_valid = 1'b1;
                            e_data = ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : seed_byte(int'(m_addr));
                        end
                        ph = 3; cnt = REC;
                    end
                end
                default: begin cnt--; if (cnt == 0) ph = 0; end
            endcase
        end
    end

    // ---------------- behavioural SRAM ----------------
    function automatic int sel_bank(input logic [3:0] csn);
        for (int k = 0; k < 4; k++) if (!csn[k]) return k;
        return -1;
    endfunction

    // Store on every cycle of the write overlap.
    always @(posedge clk) begin
        if (rst_n && sel_bank(mem_cs_n) >= 0 && !mem_we_n)
            sram_mem[int'({sel_bank(mem_cs_n) % 4, mem_addr}) & 32'h1F_FFFF] = mem_dq_out;
    end

    int          we_run = 0;
    bit          prev_both = 1'b0;
    logic [18:0] prev_addr = '0;

    // Drive read data and watch the protocol between edges.
    always @(negedge clk) begin
        bit sram_drv;
        bit both;
        int b;
        b = sel_bank(mem_cs_n);
        sram_drv = (b >= 0) && !mem_oe_n && mem_we_n;
        if (sram_drv) begin
            int unsigned a;
            a = int'({b[1:0], mem_addr});
            mem_dq_in = sram_mem.exists(a) ? sram_mem[a] : seed_byte(a);
        end else begin
            mem_dq_in = 8'h00;
        end
        if (rst_n && started) begin
            chk(!(sram_drv && mem_dq_oe), "R10", "bus driven from both sides", int'(mem_dq_oe), 0);
            both = (b >= 0) && !mem_we_n;
            if (both && prev_both)
                chk(mem_addr == prev_addr, "R8", "address moved during write", int'(mem_addr), int'(prev_addr));
            if (!mem_we_n) we_run++;
            else if (we_run > 0) begin
                chk(we_run == WP, "R5", "write pulse length", we_run, WP);
                we_run = 0;
            end
            prev_both = both;
            prev_addr = mem_addr;
        end
    end

    // ---------------- cycle compare against the reference ----------------
    always @(negedge clk) begin
        if (started) begin
            logic [3:0] ecs;
            string tag;
            ecs = (ph == 2) ? ~(4'b1 << m_addr[20:19]) : 4'hF;
            tag = (ph == 1) ? "R4" : (ph == 3) ? "R9" : "R3";
            chk(req_ready == (ph == 0), "R2", "req_ready", int'(req_ready), int'(ph == 0));
            chk(mem_cs_n == ecs, tag, "mem_cs_n", int'(mem_cs_n), int'(ecs));
            chk(mem_we_n == !(ph == 2 && m_wr), (ph == 2) ? "R5" : tag, "mem_we_n", int'(mem_we_n), int'(!(ph == 2 && m_wr)));
            chk(mem_oe_n == !(ph == 2 && !m_wr), (ph == 2) ? "R6" : tag, "mem_oe_n", int'(mem_oe_n), int'(!(ph == 2 && !m_wr)));
            chk(mem_dq_oe == (ph == 2 && m_wr), "R5", "mem_dq_oe", int'(mem_dq_oe), int'(ph == 2 && m_wr));
            if (ph == 2 && m_wr)
                chk(mem_dq_out == m_wd, "R5", "mem_dq_out", int'(mem_dq_out), int'(m_wd));
            if (ph != 0)
                chk(mem_addr == m_addr[18:0], "R8", "mem_addr", int'(mem_addr), int'(m_addr[18:0]));
            chk(rsp_valid == e_valid, "R7", "rsp_valid", int'(rsp_valid), int'(e_valid));
            if (e_valid)
                chk(rsp_rdata == e_data, "R7", "rsp_rdata", int'(rsp_rdata), int'(e_data));
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [20:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!last_accept);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (ph != 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
        chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n, "R1", "strobes in reset", int'({mem_cs_n, mem_we_n, mem_oe_n}), 8'h3F);
        chk(!mem_dq_oe && !rsp_valid, "R1", "drive/valid in reset", int'({mem_dq_oe, rsp_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_cs_n == 4'hF, "R1", "idle after reset", int'({req_ready, mem_cs_n}), 8'h1F);

        // R3: one write and read per bank
        for (int b = 0; b < 4; b++) issue(1'b1, {b[1:0], 19'h1_2345 + 19'(b)}, 8'hC0 + 8'(b));
        for (int b = 0; b < 4; b++) issue(1'b0, {b[1:0], 19'h1_2345 + 19'(b)}, 8'h00);
        // same row in two banks must not alias (R3)
        issue(1'b1, {2'd1, 19'h0_0042}, 8'h11);
        issue(1'b1, {2'd2, 19'h0_0042}, 8'h22);
        issue(1'b0, {2'd1, 19'h0_0042}, 8'h00);
        issue(1'b0, {2'd2, 19'h0_0042}, 8'h00);
        // boundaries and an unwritten location (R6, R7)
        issue(1'b1, 21'h00_0000, 8'hA1);
        issue(1'b1, 21'h1F_FFFF, 8'hB2);
        issue(1'b0, 21'h1F_FFFF, 8'h00);
        issue(1'b0, 21'h00_0000, 8'h00);
        issue(1'b0, 21'h0A_BCDE, 8'h00);
        // write then read back-to-back, then rewrite (R5, R9)
        issue(1'b1, 21'h15_5555, 8'h3C);
        issue(1'b0, 21'h15_5555, 8'h00);
        issue(1'b1, 21'h15_5555, 8'hE7);
        issue(1'b0, 21'h15_5555, 8'h00);
        drain();

        // R2: fields changed while busy; only the value at acceptance counts
        issue(1'b0, 21'h03_0303, 8'h00);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h07_7777; req_wdata = 8'h99;
        @(negedge clk);
        req_addr = 21'h0B_0B0B; req_wdata = 8'h5E;
        do @(negedge clk); while (!last_accept);
        req_valid = 1'b0;
        issue(1'b0, 21'h0B_0B0B, 8'h00);
        issue(1'b0, 21'h07_7777, 8'h00);
        drain();
        repeat (4) @(negedge clk);
        chk(req_ready && mem_cs_n == 4'hF && !rsp_valid, "R9", "quiet when finished", int'(req_ready), 1);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule